// File: doc/BRIEF.md
# Per-Queue Token Bucket Packet Policer

This block polices receive traffic per virtual queue. It sits between the stage that maps destination addresses to queues and the host receive queues. Every frame arrives tagged with a queue number and carries its byte length on its first beat. The bucket that belongs to that queue is examined once, on that first beat. The frame is then either forwarded whole or discarded whole, and nothing is ever delayed. Dropping excess frames here means they never reach the host, so they never raise interrupts there.

Each queue has its own bucket and its own settings: a refill amount, a refill period in clock cycles, a saturation depth, and a bypass bit. Software programs these at run time through a simple word-wide register port. The same port reads back a saturating count of dropped frames and the current token level for each queue.

Register addressing: `reg_addr = {queue, field[2:0]}`. The fields are:
- 0: control, where bit 0 is bypass.
- 1: refill amount.
- 2: refill period.
- 3: depth.
- 4: drop count, read-only.
- 5: token level, read-only.

Top module: `queue_policer`

## Requirements
- R1: Each queue, selected by `in_queue`, owns an independent bucket. Frames, drops and refills on one queue never change the token level or the drop count of another queue.
- R2: A non-bypassed frame passes when its queue's token level is at least `in_len`, sampled on the beat with `in_sop`=1. On a pass, `in_len` is subtracted from the token level. Otherwise the frame is dropped, its beats never appear at the output, and the token level is unchanged.
- R3: The token level never exceeds the queue's depth (field 3). A refill that would overshoot leaves the level exactly at the depth.
- R4: When the period (field 2) is N>0, the refill amount (field 1) is added once every N cycles. The first addition comes N cycles after the period is written. A period of 0 stops refilling.
- R5: The pass or drop decision made on the first beat applies to every following beat of that frame, through `in_eop`.
- R6: With bypass (field 0, bit 0) set, every frame on that queue passes and no tokens are consumed. Bypass is set for all queues after reset.
- R7: Each dropped frame increments that queue's drop count (field 4), which saturates at its all-ones value. Bypassed and passed frames are not counted.
- R8: Writing the refill amount or the period leaves the token level unchanged. Writing a depth below the current level clamps the level to the new depth in the same cycle.
- R9: After reset, `out_valid` is 0 and every token level and drop count is 0. A forwarded beat appears on the outputs exactly one cycle after it was presented, with its data, markers and queue tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_queue | input | QW | Queue tag of the frame |
| in_len | input | LENW | Frame length in bytes, valid with in_sop |
| in_data | input | DW | Beat payload |
| out_valid | output | 1 | Forwarded beat valid |
| out_sop | output | 1 | First beat marker, forwarded |
| out_eop | output | 1 | Last beat marker, forwarded |
| out_queue | output | QW | Queue tag, forwarded |
| out_data | output | DW | Payload, forwarded |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | QW+3 | Register address {queue, field} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The assertions check several properties on every cycle:
- The token level stays within the depth.
- A bypassed queue never loses tokens except through a depth clamp.
- Drop counts never decrease.
- An output beat is always preceded by an input beat.
- A first beat that is short of tokens produces no output.

Other behaviour needs concrete stimulus and known token levels, so only the directed scenarios can show it:
- The exact refill timing.
- The boundary where the length equals the level.
- Saturation of both the bucket and the drop counter.
- Clamping on a smaller depth.
- A decision that persists across every beat of a multi-beat frame.
- Isolation between queues while one of them floods.

// File: rtl/queue_policer.sv
module queue_policer #(
  parameter int NQ   = 4,
  parameter int DW   = 32,
  parameter int LENW = 16,
  parameter int TOKW = 20,
  parameter int IVW  = 16,
  parameter int CNTW = 8,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int AW  = QW + 3,
  localparam int RW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic            in_eop,
  input  logic [QW-1:0]   in_queue,
  input  logic [LENW-1:0] in_len,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  output logic            out_sop,
  output logic            out_eop,
  output logic [QW-1:0]   out_queue,
  output logic [DW-1:0]   out_data,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata
);
  // NQ is expected to be a power of two; TOKW >= LENW.
  localparam logic [2:0] F_CTRL = 3'd0;
  localparam logic [2:0] F_INC  = 3'd1;
  localparam logic [2:0] F_IVL  = 3'd2;
  localparam logic [2:0] F_DEP  = 3'd3;
  localparam logic [2:0] F_DROP = 3'd4;
  localparam logic [2:0] F_TOK  = 3'd5;

  logic [NQ-1:0]   byp;
  logic [TOKW-1:0] inc_r [NQ];
  logic [TOKW-1:0] dep_r [NQ];
  logic [TOKW-1:0] tok   [NQ];
  logic [IVW-1:0]  ivl   [NQ];
  logic [IVW-1:0]  tmr   [NQ];
  logic [CNTW-1:0] drops [NQ];
  logic            keep;

  wire [QW-1:0]   rq       = reg_addr[AW-1:3];
  wire [2:0]      rf       = reg_addr[2:0];
  wire            sop_in   = in_valid & in_sop;
  wire [TOKW-1:0] cost     = TOKW'(in_len);
  wire            fits     = tok[in_queue] >= cost;
  wire            pass_sop = byp[in_queue] | fits;
  wire            pass_now = in_sop ? pass_sop : keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep      <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_queue <= '0;
      out_data  <= '0;
    end else begin
      if (sop_in) keep <= pass_sop;
      out_valid <= in_valid & pass_now;
      out_sop   <= in_sop;
      out_eop   <= in_eop;
      out_queue <= in_queue;
      out_data  <= in_data;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_bkt
    wire            hit   = sop_in && (in_queue == QW'(g));
    wire            take  = hit && !byp[g] && fits;
    wire            drop  = hit && !byp[g] && !fits;
    wire            wsel  = reg_wr && (rq == QW'(g));
    wire            tick  = (ivl[g] != '0) && (tmr[g] == ivl[g] - 1'b1);
    wire [TOKW-1:0] left  = tok[g] - (take ? cost : '0);
    wire [TOKW:0]   sum   = {1'b0, left} + {1'b0, inc_r[g]};
    wire [TOKW-1:0] fill  = !tick ? left :
                            (sum > {1'b0, dep_r[g]}) ? dep_r[g] : sum[TOKW-1:0];
    wire [TOKW-1:0] dep_n = (wsel && rf == F_DEP) ? reg_wdata[TOKW-1:0] : dep_r[g];
    wire [TOKW-1:0] tok_n = (fill > dep_n) ? dep_n : fill;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byp[g]   <= 1'b1;
        inc_r[g] <= '0;
        dep_r[g] <= '0;
        ivl[g]   <= '0;
        tmr[g]   <= '0;
        tok[g]   <= '0;
        drops[g] <= '0;
      end else begin
        tok[g]   <= tok_n;
        dep_r[g] <= dep_n;
        if (wsel && rf == F_CTRL) byp[g]   <= reg_wdata[0];
        if (wsel && rf == F_INC)  inc_r[g] <= reg_wdata[TOKW-1:0];
        if (wsel && rf == F_IVL) begin
          ivl[g] <= reg_wdata[IVW-1:0];
          tmr[g] <= '0;
        end else if (tick)
          tmr[g] <= '0;
        else if (ivl[g] != '0)
          tmr[g] <= tmr[g] + 1'b1;
        if (drop && drops[g] != '1) drops[g] <= drops[g] + 1'b1;
      end
    end

    a_r3_tok_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
      tok[g] <= dep_r[g]);
    a_r6_bypass_no_spend: assert property (@(posedge clk) disable iff (!rst_n)
      byp[g] && !(wsel && rf == F_DEP) |=> tok[g] >= $past(tok[g]));
    a_r7_drops_never_fall: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> drops[g] >= $past(drops[g]));
  end

  always_comb begin
    reg_rdata = '0;
    case (rf)
      F_CTRL:  reg_rdata[0] = byp[rq];
      F_INC:   reg_rdata[TOKW-1:0] = inc_r[rq];
      F_IVL:   reg_rdata[IVW-1:0]  = ivl[rq];
      F_DEP:   reg_rdata[TOKW-1:0] = dep_r[rq];
      F_DROP:  reg_rdata[CNTW-1:0] = drops[rq];
      F_TOK:   reg_rdata[TOKW-1:0] = tok[rq];
      default: reg_rdata = '0;
    endcase
  end

  a_r9_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  a_r2_short_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sop_in && !byp[in_queue] && (tok[in_queue] < cost) |=> !out_valid);
endmodule

// File: tb/tb_queue_policer.sv
module tb_queue_policer;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int QW = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [QW-1:0] in_queue = '0;
  logic [15:0] in_len = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sop, out_eop;
  logic [QW-1:0] out_queue;
  logic [DW-1:0] out_data;
  logic reg_wr = 0;
  logic [QW+2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  int sops_seen [NQ];
  int beats_seen [NQ];

  queue_policer dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_queue(in_queue), .in_len(in_len), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_queue(out_queue), .out_data(out_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < NQ; i++) begin sops_seen[i] = 0; beats_seen[i] = 0; end

  always @(negedge clk) if (rst_n && out_valid) begin
    beats_seen[out_queue] = beats_seen[out_queue] + 1;
    if (out_sop) sops_seen[out_queue] = sops_seen[out_queue] + 1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int q, input int f, input int v);
    reg_addr = {QW'(q), 3'(f)}; reg_wdata = v; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int q, input int f, output int v);
    reg_addr = {QW'(q), 3'(f)};
    #1 v = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input int q, input int f, input int exp);
    int v;
    rd(q, f, v);
    chk(tag, v, exp);
  endtask

  task automatic send(input int q, input int len, input int nb);
    for (int b = 0; b < nb; b++) begin
      in_valid = 1; in_sop = (b == 0); in_eop = (b == nb - 1);
      in_queue = QW'(q); in_len = 16'(len); in_data = 32'(len * 16 + b);
      @(negedge clk);
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic frame(input string tag, input int q, input int len, input int nb, input bit pass);
    int s0, b0;
    s0 = sops_seen[q]; b0 = beats_seen[q];
    send(q, len, nb);
    @(negedge clk);
    chk({tag, " frames"}, sops_seen[q] - s0, pass ? 1 : 0);
    chk({tag, " beats"}, beats_seen[q] - b0, pass ? nb : 0);
  endtask

  task automatic t_reset;
    chk("R9 out_valid after reset", out_valid, 0);
    for (int q = 0; q < NQ; q++) begin
      chk_reg("R6 bypass after reset", q, 0, 1);
      chk_reg("R9 tokens after reset", q, 5, 0);
      chk_reg("R9 drops after reset", q, 4, 0);
    end
  endtask

  task automatic t_bypass;
    int b0;
    b0 = beats_seen[0];
    in_valid = 1; in_sop = 1; in_eop = 0; in_queue = 0; in_len = 16'd1000; in_data = 32'hCAFE;
    @(negedge clk);
    in_valid = 0; in_sop = 0;
    chk("R9 data forwarded after one cycle", out_data, 32'hCAFE);
    chk("R9 out_valid one cycle later", out_valid, 1);
    in_valid = 1; in_eop = 1; in_data = 32'h1;
    @(negedge clk);
    in_valid = 0; in_eop = 0;
    @(negedge clk);
    chk("R6 bypass frame beats", beats_seen[0] - b0, 2);
    frame("R6 bypass frame 3 beats", 0, 1000, 3, 1);
    chk_reg("R6 bypass consumes no tokens", 0, 5, 0);
    chk_reg("R7 bypass not counted", 0, 4, 0);
  endtask

  task automatic t_spend;
    wr(1, 3, 500); wr(1, 1, 500); wr(1, 2, 1); wr(1, 2, 0); wr(1, 0, 0);
    chk_reg("R3 filled to depth", 1, 5, 500);
    frame("R2 pass len 200", 1, 200, 3, 1);
    chk_reg("R2 tokens after pass", 1, 5, 300);
    frame("R5 dropped 2-beat frame", 1, 400, 2, 0);
    chk_reg("R2 tokens unchanged on drop", 1, 5, 300);
    chk_reg("R7 drop counted", 1, 4, 1);
    frame("R2 equal length passes", 1, 300, 1, 1);
    chk_reg("R2 tokens reach zero", 1, 5, 0);
  endtask

  task automatic t_saturate;
    wr(2, 0, 0); wr(2, 3, 100); wr(2, 1, 70); wr(2, 2, 1);
    repeat (4) @(negedge clk);
    wr(2, 2, 0);
    chk_reg("R3 saturate at depth", 2, 5, 100);
  endtask

  task automatic t_refill;
    wr(3, 0, 0); wr(3, 3, 1000); wr(3, 1, 10);
    wr(3, 2, 5);
    repeat (11) @(negedge clk);
    wr(3, 2, 0);
    chk_reg("R4 two refills in 12 cycles", 3, 5, 20);
    repeat (20) @(negedge clk);
    chk_reg("R4 period zero stops refill", 3, 5, 20);
  endtask

  task automatic t_isolation;
    for (int i = 0; i < 5; i++) frame("R1 flooding queue dropped", 1, 64, 1, 0);
    chk_reg("R1 flood drops counted", 1, 4, 6);
    chk_reg("R1 other queue tokens intact", 2, 5, 100);
    chk_reg("R1 other queue no drops", 3, 4, 0);
    frame("R1 other queue passes", 3, 20, 2, 1);
    chk_reg("R1 other queue spent", 3, 5, 0);
    chk_reg("R1 flood queue unchanged", 1, 5, 0);
  endtask

  task automatic t_clamp;
    wr(2, 3, 40);
    chk_reg("R8 clamp to smaller depth", 2, 5, 40);
    wr(2, 1, 5);
    chk_reg("R8 rate write keeps tokens", 2, 5, 40);
    wr(2, 3, 200);
    chk_reg("R8 larger depth keeps tokens", 2, 5, 40);
    wr(2, 2, 0);
    chk_reg("R8 period write keeps tokens", 2, 5, 40);
  endtask

  task automatic t_drop_sat;
    int b0;
    b0 = beats_seen[1];
    for (int i = 0; i < 300; i++) send(1, 64, 1);
    @(negedge clk);
    chk("R7 flood forwards nothing", beats_seen[1] - b0, 0);
    chk_reg("R7 drop count saturates", 1, 4, 255);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_bypass;
    t_spend;
    t_saturate;
    t_refill;
    t_isolation;
    t_clamp;
    t_drop_sat;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule